// File: doc/BRIEF.md
# Four-Port Shared Word Memory with Per-Port Write Veto

A 2048-word by 8-bit storage block with four identical, independent ports, each able to read or write any word at any time, including a word that another port is using in the same cycle. The block has no arbiter. Keeping writers apart is the job of the surrounding logic, which can hold off a port by pulling that port's active-low hold input. A held port's writes are dropped, but its reads go on as normal.

The block is fully synchronous to one clock. Each port has an active-low select, a read/write select (high reads, low writes), an active-low output enable, an address and write data. The pad-level high-impedance behaviour is modelled by a per-port drive-enable output. The read data output is forced to zero whenever the port is not driving. If two or more enabled, unheld ports write the same word in one cycle, the result is fixed: the port with the smallest index wins, and a clash flag reports the event one cycle later.

The asynchronous active-low reset is released through a two-stage synchronizer. Outputs stay quiet until two rising edges after the reset input goes high.

Top module: `quadram_core`

## Requirements
- R1: A port with sel_n=0, rd_nwr=0 and hold_n=1 stores its wdata at its addr on the rising edge. Any port that reads that word from the next cycle on returns the new value, including address 0 and address 2047.
- R2: With hold_n=0, a write on that port leaves the memory unchanged. A read on that port (sel_n=0, rd_nwr=1, oe_n=0) still drives the stored data.
- R3: With sel_n=1, a port neither writes nor reads. In the cycle after such a sample its rdrive is 0 and its rdata is 0.
- R4: A read sampled with sel_n=0, rd_nwr=1 presents the addressed word one cycle later. rdrive is 1 only if oe_n was 0 at that sample, and rdata is 0 whenever rdrive is 0.
- R5: A port sampled in write mode (sel_n=0, rd_nwr=0) has rdrive=0 in the following cycle, whatever oe_n is.
- R6: If several writing ports share an address in one cycle, the word takes the data of the writing port with the lowest index (port 0 first, port 3 last).
- R7: collide is 1 in the cycle after an edge at which at least two writing ports (enabled, write mode, not held) shared an address, and 0 otherwise.
- R8: A read sampled in the same cycle as a write to the same word returns the old contents. The new value is returned by a read sampled in the following cycle.
- R9: While rst_n is 0, and for two rising edges after it rises, rdrive and collide are 0 and rdata is 0.
- R10: All four ports reading the same word in one cycle all receive that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_n | input | 4 | Per-port active-low select, bit p for port p |
| rd_nwr | input | 4 | Per-port mode, 1 read, 0 write |
| oe_n | input | 4 | Per-port active-low output enable |
| hold_n | input | 4 | Per-port active-low write veto |
| addr | input | 4x11 | Per-port word address, element p for port p |
| wdata | input | 4x8 | Per-port write data |
| rdata | output | 4x8 | Per-port registered read data, zero when not driving |
| rdrive | output | 4 | Per-port drive enable for the read data |
| collide | output | 1 | Same-address write clash seen at the previous edge |

## Verification
Every result the block produces (read data, drive enable and the clash flag) belongs to the rising edge at which the inputs were sampled and is visible from just after that edge. Memory contents written at edge k are visible to a read sampled at edge k+1, and the read returns them just after edge k+1. The bench drives each cycle's stimulus at the falling edge and pushes the expected outputs for it at that moment. A monitor pops that entry one nanosecond after the next rising edge and compares it, so each result is checked in exactly the cycle it is due. The only longer delay is reset release, which takes two extra edges. That delay is checked with explicit per-edge samples.

// File: rtl/quadram_pkg.sv
package quadram_pkg;

  typedef enum logic [1:0] {
    QR_IDLE  = 2'd0,
    QR_READ  = 2'd1,
    QR_WRITE = 2'd2,
    QR_HELD  = 2'd3
  } qr_op_e;

  // Per-port access kind from the raw control pins.
  function automatic qr_op_e qr_decode(input logic sel_n, input logic rd_nwr,
                                       input logic hold_n);
    if (sel_n)       return QR_IDLE;
    else if (rd_nwr) return QR_READ;
    else if (hold_n) return QR_WRITE;
    else             return QR_HELD;
  endfunction

endpackage

// File: rtl/quadram_rst_sync.sv
module quadram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/quadram_wr_resolve.sv
module quadram_wr_resolve #(
  parameter int NP = 4,
  parameter int AW = 11
) (
  input  logic [NP-1:0]         wreq,
  input  logic [NP-1:0][AW-1:0] addr,
  output logic [NP-1:0]         grant,
  output logic                  clash
);
  // Fixed priority: a writer loses to any lower-index writer on the same word.
  always_comb begin
    grant = wreq;
    clash = 1'b0;
    for (int i = 1; i < NP; i++) begin
      for (int j = 0; j < i; j++) begin
        if (wreq[i] && wreq[j] && (addr[i] == addr[j])) begin
          grant[i] = 1'b0;
          clash    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/quadram_array.sv
module quadram_array #(
  parameter int NP = 4,
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic [NP-1:0]         grant,
  input  logic [NP-1:0][AW-1:0] addr,
  input  logic [NP-1:0][DW-1:0] wdata,
  output logic [NP-1:0][DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Granted writers never share an address, so loop order is irrelevant.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (grant[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rword[p] = mem[addr[p]];
  end
endmodule

// File: rtl/quadram_rd_port.sv
module quadram_rd_port
  import quadram_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  qr_op_e        op,
  input  logic          oe_n,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] rdata,
  output logic          rdrive
);
  logic          load;
  logic          drv_d, drv_q;
  logic [DW-1:0] data_d, data_q;

  always_comb begin
    load   = (op == QR_READ);
    drv_d  = load && !oe_n;
    data_d = load ? word_in : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= 1'b0;
      data_q <= '0;
    end else begin
      drv_q  <= drv_d;
      data_q <= data_d;
    end
  end

  assign rdrive = drv_q;
  assign rdata  = drv_q ? data_q : '0;
endmodule

// File: rtl/quadram_core.sv
module quadram_core
  import quadram_pkg::*;
#(
  parameter int NP = 4,
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         sel_n,
  input  logic [NP-1:0]         rd_nwr,
  input  logic [NP-1:0]         oe_n,
  input  logic [NP-1:0]         hold_n,
  input  logic [NP-1:0][AW-1:0] addr,
  input  logic [NP-1:0][DW-1:0] wdata,
  output logic [NP-1:0][DW-1:0] rdata,
  output logic [NP-1:0]         rdrive,
  output logic                  collide
);
  localparam int SYNC_STAGES = 2;

  logic                  rst_i_n;
  qr_op_e                op [NP];
  logic [NP-1:0]         wreq;
  logic [NP-1:0]         grant;
  logic [NP-1:0][DW-1:0] rword;
  logic                  clash;
  logic                  collide_d, collide_q;

  quadram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign op[p]   = qr_decode(sel_n[p], rd_nwr[p], hold_n[p]);
    assign wreq[p] = (op[p] == QR_WRITE);

    quadram_rd_port #(.DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_i_n), .op(op[p]), .oe_n(oe_n[p]),
      .word_in(rword[p]), .rdata(rdata[p]), .rdrive(rdrive[p])
    );
  end

  quadram_wr_resolve #(.NP(NP), .AW(AW)) u_res (
    .wreq(wreq), .addr(addr), .grant(grant), .clash(clash)
  );

  quadram_array #(.NP(NP), .AW(AW), .DW(DW)) u_mem (
    .clk(clk), .grant(grant), .addr(addr), .wdata(wdata), .rword(rword)
  );

  always_comb begin
    collide_d = clash;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) collide_q <= 1'b0;
    else          collide_q <= collide_d;
  end

  assign collide = collide_q;
endmodule

// File: rtl/quadram_chk.sv
module quadram_chk #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] sel_n,
  input logic [NP-1:0] rd_nwr,
  input logic [NP-1:0] oe_n,
  input logic [NP-1:0] hold_n,
  input logic [NP-1:0] rdrive,
  input logic          collide
);
  logic [NP-1:0] wr_vec;
  logic [1:0]    up_cnt;
  logic          ready;

  assign wr_vec = ~sel_n & ~rd_nwr & hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end
  assign ready = (up_cnt == 2'd3);

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (rdrive == '0 && !collide))
    else $error("reset outputs not quiet");

  p_single_writer_calm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_vec) < 2) |=> !collide)
    else $error("clash flag without two writers");

  for (genvar g = 0; g < NP; g++) begin : g_port
    p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n[g] |=> !rdrive[g])
      else $error("deselected port drives");

    p_write_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n[g] && !rd_nwr[g]) |=> !rdrive[g])
      else $error("writing port drives");

    p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[g] |=> !rdrive[g])
      else $error("drive without output enable");

    p_held_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !sel_n[g] && rd_nwr[g] && !oe_n[g] && !hold_n[g]) |=> rdrive[g])
      else $error("hold blocked a read");
  end
endmodule

bind quadram_core quadram_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_nwr(rd_nwr), .oe_n(oe_n),
  .hold_n(hold_n), .rdrive(rdrive), .collide(collide)
);

// File: tb/quadram_core_tb.sv
`timescale 1ns/1ps
module quadram_core_tb;
  localparam int NP = 4;
  localparam int AW = 11;
  localparam int DW = 8;

  logic                  clk;
  logic                  rst_n;
  logic [NP-1:0]         sel_n, rd_nwr, oe_n, hold_n;
  logic [NP-1:0][AW-1:0] addr;
  logic [NP-1:0][DW-1:0] wdata;
  logic [NP-1:0][DW-1:0] rdata;
  logic [NP-1:0]         rdrive;
  logic                  collide;

  int nchk;
  int nfail;

  typedef struct packed {
    logic [NP-1:0][DW-1:0] rd;
    logic [NP-1:0]         drv;
    logic                  col;
  } exp_t;

  exp_t  sbq [$];
  string tagq [$];
  logic [DW-1:0] model [1 << AW];

  quadram_core #(.NP(NP), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_nwr(rd_nwr), .oe_n(oe_n),
    .hold_n(hold_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdrive(rdrive), .collide(collide)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, expv);
    end
  endtask

  task automatic idle_all();
    sel_n = '1; rd_nwr = '1; oe_n = '0; hold_n = '1; addr = '0; wdata = '0;
  endtask

  task automatic set_wr(input int p, input int a, input int d);
    sel_n[p] = 1'b0; rd_nwr[p] = 1'b0; addr[p] = AW'(a); wdata[p] = DW'(d);
  endtask

  task automatic set_rd(input int p, input int a);
    sel_n[p] = 1'b0; rd_nwr[p] = 1'b1; oe_n[p] = 1'b0; addr[p] = AW'(a);
  endtask

  // Driver: compute expected outputs of this cycle, push, advance one cycle.
  task automatic apply(input string tag);
    exp_t e;
    logic [NP-1:0] wr;
    e = '0;
    for (int p = 0; p < NP; p++) begin
      wr[p] = !sel_n[p] && !rd_nwr[p] && hold_n[p];
      if (!sel_n[p] && rd_nwr[p] && !oe_n[p]) begin
        e.drv[p] = 1'b1;
        e.rd[p]  = model[addr[p]];
      end
    end
    for (int i = 0; i < NP; i++)
      for (int j = i + 1; j < NP; j++)
        if (wr[i] && wr[j] && addr[i] == addr[j]) e.col = 1'b1;
    for (int p = NP - 1; p >= 0; p--)
      if (wr[p]) model[addr[p]] = wdata[p];
    sbq.push_back(e);
    tagq.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    idle_all();
  endtask

  // Monitor: compare one item just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t  e;
        string t;
        e = sbq.pop_front();
        t = tagq.pop_front();
        for (int p = 0; p < NP; p++) begin
          chk(rdrive[p] === e.drv[p], t, $sformatf("rdrive[%0d]", p),
              int'(rdrive[p]), int'(e.drv[p]));
          chk(rdata[p] === e.rd[p], t, $sformatf("rdata[%0d]", p),
              int'(rdata[p]), int'(e.rd[p]));
        end
        chk(collide === e.col, t, "collide", int'(collide), int'(e.col));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0;
    rst_n = 1'b0;
    idle_all();
    repeat (4) @(negedge clk);
    chk(rdrive === '0, "R9 in reset", "rdrive", int'(rdrive), 0);
    chk(rdata === '0, "R9 in reset", "rdata", int'(rdata), 0);
    chk(collide === 1'b0, "R9 in reset", "collide", int'(collide), 0);

    // Release with a read pending: two edges still quiet, third drives.
    rst_n = 1'b1;
    set_rd(0, 0);
    @(posedge clk); #1;
    chk(rdrive[0] === 1'b0, "R9 sync edge 1", "rdrive[0]", int'(rdrive[0]), 0);
    @(posedge clk); #1;
    chk(rdrive[0] === 1'b0, "R9 sync edge 2", "rdrive[0]", int'(rdrive[0]), 0);
    chk(rdata[0] === '0, "R9 sync edge 2", "rdata[0]", int'(rdata[0]), 0);
    @(posedge clk); #1;
    chk(rdrive[0] === 1'b1, "R9 sync edge 3", "rdrive[0]", int'(rdrive[0]), 1);
    @(negedge clk);
    idle_all();

    set_wr(0, 0, 8'h11); set_wr(1, 2047, 8'h22); set_wr(2, 5, 8'hA5); set_wr(3, 7, 8'h07);
    apply("R1/R5 boundary writes");
    set_rd(0, 2047); set_rd(1, 5); set_rd(2, 7); set_rd(3, 0);
    apply("R1 cross read");

    set_wr(2, 5, 8'h3C); hold_n[2] = 1'b0;
    set_wr(3, 0, 8'h5A); hold_n[3] = 1'b0;
    set_rd(1, 5); hold_n[1] = 1'b0;
    apply("R2 held writes");
    set_rd(0, 5); set_rd(1, 0); hold_n[1] = 1'b0; set_rd(2, 5);
    apply("R2 memory kept");

    set_wr(0, 5, 8'hFF); sel_n[0] = 1'b1;
    set_rd(1, 5); sel_n[1] = 1'b1;
    apply("R3 deselected");
    set_rd(3, 5);
    apply("R3 no write happened");

    set_rd(0, 2047); oe_n[0] = 1'b1; set_rd(1, 2047);
    apply("R4 output enable");

    set_wr(0, 100, 8'h81); set_wr(1, 100, 8'h82); set_wr(2, 100, 8'h83); set_wr(3, 100, 8'h84);
    oe_n = '0;
    apply("R6/R7 four-way clash");
    set_rd(3, 100);
    apply("R6 lowest index kept");

    set_wr(1, 200, 8'hC1); set_wr(3, 200, 8'hC3); set_wr(0, 300, 8'hD0);
    set_wr(2, 200, 8'hC2); hold_n[2] = 1'b0;
    apply("R7 pair clash with held port");
    set_wr(2, 301, 8'hE2); set_wr(3, 302, 8'hE3); set_rd(0, 200);
    apply("R6/R7 distinct words");

    set_wr(0, 7, 8'h77); set_rd(1, 7); set_rd(2, 7);
    apply("R8 same cycle old data");
    set_rd(1, 7);
    apply("R8 new data next cycle");

    for (int p = 0; p < NP; p++) set_rd(p, 100);
    apply("R10 shared read");

    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < NP; p++) set_wr(p, 16 + 4 * k + p, 8'h40 + 4 * k + p);
      apply("R1 fill");
    end

    for (int n = 0; n < 160; n++) begin
      for (int p = 0; p < NP; p++) begin
        sel_n[p]  = ($urandom_range(0, 4) == 0);
        rd_nwr[p] = $urandom_range(0, 1) == 1;
        oe_n[p]   = ($urandom_range(0, 5) == 0);
        hold_n[p] = ($urandom_range(0, 4) != 0);
        addr[p]   = AW'(16 + $urandom_range(0, 7));
        wdata[p]  = DW'($urandom_range(0, 255));
      end
      apply("mixed R1 R2 R4 R6 R7 R8");
    end

    apply("idle tail");
    @(posedge clk); #2;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule